// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block holds the per-source state of a vectored interrupt controller: an enable flag, a pending flag, an active (in-service) flag and a 5-bit priority for each of up to 35 sources. Software reaches that state through a simple synchronous register bus. Enables and pending flags each have a pair of registers, one that sets bits and one that clears them. Both registers of a pair read back the same live state, so software can change one bit without a read-modify-write. Priorities are packed four to a 32-bit word. A write-only trigger register lets software mark any source pending by writing its number.

On the hardware side, each source has a request line. A rising edge on that line marks the source pending. An active-status vector from the core reports which handlers are running. When a source becomes active, its pending flag is dropped unless its request line is still high. The block drives an enabled-and-pending vector for downstream arbitration. Arbitration, vector fetch, nesting and exception entry are handled elsewhere.

Read data is combinational from the address. Writes take effect at the clock edge on which `bus_we` is sampled high.

Top module: `irq_regbank`

## Requirements
- R1: After reset, every readable word returns zero and `irq_out` is all zero.
- R2: A write to a set-enable word (0x100 holds sources 0–31, 0x104 holds sources 32–34; source i sits at bit i%32) sets each enable whose data bit is 1 and leaves the others unchanged. The set-enable and clear-enable words at the same word index both read back the current enable flags.
- R3: A write to a clear-enable word (0x180 for sources 0–31, 0x184 for sources 32–34) clears each enable whose data bit is 1 and leaves the others unchanged.
- R4: Pending flags use the same set/clear scheme and bit layout, with set words at 0x200/0x204 and clear words at 0x280/0x284. All four words read back the current pending flags.
- R5: Active words at 0x300/0x304 read the `core_active` vector as it was sampled at the previous clock edge. Writes to them have no effect.
- R6: Priority word k, at 0x400 + 4k for k from 0 to 8, holds source 4k+b in bits [8b+7:8b+3]. A write replaces all four fields of the word. Bits [8b+2:8b] always read zero.
- R7: Writing a value n in bits [8:0] to 0xF00 sets the pending flag of source n when n < 35. A larger n changes nothing. Reading 0xF00 returns zero.
- R8: A low-to-high transition on `irq_req[i]`, as seen between two clock edges, sets pending flag i at the later edge.
- R9: A low-to-high transition on `core_active[i]` clears pending flag i if `irq_req[i]` is low in that cycle, and leaves it set if `irq_req[i]` is high.
- R10: When a clear-pending write and a request rising edge hit the same source in the same cycle, the flag ends up set.
- R11: Bits for source numbers 35 and above read as zero and ignore writes. This covers bits 3–31 of the second flag words and the byte for source 35 in priority word 8. Any address not listed in R2–R7 reads zero.
- R12: `irq_out[i]` is high exactly when enable i and pending flag i are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_req | input | 35 | Per-source request lines |
| core_active | input | 35 | Per-source in-service status from the core |
| irq_out | output | 35 | Per-source enabled-and-pending |

## Verification
The in-RTL assertions check these rules on every cycle:
- a flag with no set or clear request holds its value;
- a hardware set always lands, even against a software clear;
- a software clear with no competing set takes effect;
- priority fields hold when not written;
- the low three bits of every priority byte, and the trigger register, read zero.

Some behaviour only the bench scenarios can show. This includes the exact bit placement of each source in the set/clear pairs and in the packed priority words, and the fact that out-of-range trigger numbers and unimplemented bits are truly dropped. It also includes the rule that an active edge clears pending only while the request is low. The bench checks all of these against a reference model driven by random bus traffic and request toggling.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

    localparam logic [11:0] OFS_EN_SET = 12'h100;
    localparam logic [11:0] OFS_EN_CLR = 12'h180;
    localparam logic [11:0] OFS_PD_SET = 12'h200;
    localparam logic [11:0] OFS_PD_CLR = 12'h280;
    localparam logic [11:0] OFS_ACT    = 12'h300;
    localparam logic [11:0] OFS_PRIO   = 12'h400;
    localparam logic [11:0] OFS_TRIG   = 12'hF00;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR,
        SEL_ACT,
        SEL_PRIO,
        SEL_TRIG
    } reg_sel_e;

endpackage

// File: rtl/irq_setclr_vec.sv
module irq_setclr_vec #(
    parameter int N = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] hw_clr,
    output logic [N-1:0] q
);

    typedef struct packed {
        logic [N-1:0] flags;
    } vec_state_t;

    vec_state_t state_d, state_q;

    // sets dominate clears, so hardware set beats a software clear
    always_comb begin
        state_d = state_q;
        state_d.flags = (state_q.flags & ~sw_clr & ~hw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q = state_q.flags;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sw_set | sw_clr | hw_set | hw_clr)) |=> $stable(q));

    p_hw_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));

    p_sw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr & ~sw_set & ~hw_set)) |=>
        ((q & $past(sw_clr & ~sw_set & ~hw_set)) == '0));

endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
    parameter int N  = 35,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_idx,
    input  logic [31:0]   wr_data,
    output logic [N*PW-1:0] prio_flat
);

    localparam int LOW = 8 - PW;

    typedef struct packed {
        logic [N-1:0][PW-1:0] field;
    } prio_state_t;

    prio_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en && (i / 4) == int'(wr_idx))
                state_d.field[i] = wr_data[8*(i%4)+LOW +: PW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign prio_flat = state_q.field;

    p_prio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(prio_flat));

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_regbank_pkg::*;
#(
    parameter int NUM_SRC = 35,
    parameter int PRIO_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] core_active,
    output logic [NUM_SRC-1:0] irq_out
);

    localparam int FLAG_WORDS = (NUM_SRC + 31) / 32;
    localparam int PRIO_WORDS = (NUM_SRC + 3) / 4;
    localparam int LOW        = 8 - PRIO_W;

    typedef struct packed {
        logic [NUM_SRC-1:0] req;
        logic [NUM_SRC-1:0] act;
    } edge_state_t;

    edge_state_t state_d, state_q;

    reg_sel_e           sel;
    logic [7:0]         widx;
    logic [NUM_SRC-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [NUM_SRC-1:0] req_rise, act_rise, pd_hw_clr;
    logic [NUM_SRC-1:0] en_q, pd_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic               prio_wr;

    // address decode
    always_comb begin
        sel  = SEL_NONE;
        widx = 8'd0;
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr == OFS_TRIG) begin
                sel = SEL_TRIG;
            end else if (bus_addr[11:10] == OFS_PRIO[11:10]) begin
                widx = bus_addr[9:2];
                if (int'(widx) < PRIO_WORDS) sel = SEL_PRIO;
            end else begin
                widx = {3'b000, bus_addr[6:2]};
                if (int'(widx) < FLAG_WORDS) begin
                    unique case (bus_addr[11:7])
                        OFS_EN_SET[11:7]: sel = SEL_EN_SET;
                        OFS_EN_CLR[11:7]: sel = SEL_EN_CLR;
                        OFS_PD_SET[11:7]: sel = SEL_PD_SET;
                        OFS_PD_CLR[11:7]: sel = SEL_PD_CLR;
                        OFS_ACT[11:7]:    sel = SEL_ACT;
                        default:          sel = SEL_NONE;
                    endcase
                end
            end
        end
    end

    // per-source write masks
    always_comb begin
        en_set = '0;
        en_clr = '0;
        pd_set = '0;
        pd_clr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_we && (i / 32) == int'(widx) && bus_wdata[i%32]) begin
                en_set[i] = (sel == SEL_EN_SET);
                en_clr[i] = (sel == SEL_EN_CLR);
                pd_set[i] = (sel == SEL_PD_SET);
                pd_clr[i] = (sel == SEL_PD_CLR);
            end
            if (bus_we && sel == SEL_TRIG && int'(bus_wdata[8:0]) == i)
                pd_set[i] = 1'b1;
        end
    end

    assign prio_wr = bus_we && (sel == SEL_PRIO);

    // edge tracking for requests and active status
    always_comb begin
        state_d     = state_q;
        state_d.req = irq_req;
        state_d.act = core_active;
        req_rise    = irq_req & ~state_q.req;
        act_rise    = core_active & ~state_q.act;
        pd_hw_clr   = act_rise & ~irq_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    irq_setclr_vec #(.N(NUM_SRC)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (en_set),
        .sw_clr (en_clr),
        .hw_set ({NUM_SRC{1'b0}}),
        .hw_clr ({NUM_SRC{1'b0}}),
        .q      (en_q)
    );

    irq_setclr_vec #(.N(NUM_SRC)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (pd_set),
        .sw_clr (pd_clr),
        .hw_set (req_rise),
        .hw_clr (pd_hw_clr),
        .q      (pd_q)
    );

    irq_prio_bank #(.N(NUM_SRC), .PW(PRIO_W)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prio_wr),
        .wr_idx    (widx),
        .wr_data   (bus_wdata),
        .prio_flat (prio_flat)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if ((i / 32) == int'(widx)) begin
                unique case (sel)
                    SEL_EN_SET, SEL_EN_CLR: bus_rdata[i%32] = en_q[i];
                    SEL_PD_SET, SEL_PD_CLR: bus_rdata[i%32] = pd_q[i];
                    SEL_ACT:                bus_rdata[i%32] = state_q.act[i];
                    default: ;
                endcase
            end
            if (sel == SEL_PRIO && (i / 4) == int'(widx))
                bus_rdata[8*(i%4)+LOW +: PRIO_W] = prio_flat[i*PRIO_W +: PRIO_W];
        end
    end

    assign irq_out = en_q & pd_q;

    p_prio_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:10] == 2'b01) |-> ((bus_rdata & 32'h0707_0707) == 32'h0));

    p_trig_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_TRIG) |-> (bus_rdata == 32'h0));

    p_pending_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_rise) |=> ((pd_q & $past(req_rise)) == $past(req_rise)));

endmodule

// File: tb/irq_regbank_tb.sv
module irq_regbank_tb;

    localparam int NS = 35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] irq_req = '0;
    logic [NS-1:0] core_active = '0;
    logic [NS-1:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;

    logic [NS-1:0] en_m = '0, pd_m = '0, act_m = '0, reqp_m = '0, actp_m = '0;
    logic [4:0]    prio_m [NS];

    irq_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .core_active(core_active), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    function automatic logic [NS-1:0] mask_of(input logic [11:0] a, input logic [11:0] base,
                                              input logic [31:0] d);
        logic [63:0] w = '0;
        if (a == base)          w[31:0]  = d;
        if (a == base + 12'h4)  w[63:32] = d;
        return w[NS-1:0];
    endfunction

    function automatic logic [31:0] word_of(input logic [NS-1:0] v, input int k);
        logic [63:0] w = {{(64-NS){1'b0}}, v};
        return k == 0 ? w[31:0] : w[63:32];
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [31:0] r = '0;
        if (a == 12'h100 || a == 12'h180) r = word_of(en_m, 0);
        if (a == 12'h104 || a == 12'h184) r = word_of(en_m, 1);
        if (a == 12'h200 || a == 12'h280) r = word_of(pd_m, 0);
        if (a == 12'h204 || a == 12'h284) r = word_of(pd_m, 1);
        if (a == 12'h300) r = word_of(act_m, 0);
        if (a == 12'h304) r = word_of(act_m, 1);
        if (a >= 12'h400 && a <= 12'h420 && a[1:0] == 2'b00) begin
            for (int b = 0; b < 4; b++) begin
                int s = int'((a - 12'h400) >> 2) * 4 + b;
                if (s < NS) r[8*b+3 +: 5] = prio_m[s];
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (a[11:8] == 4'h1) return a[7] ? "R3" : "R2";
        if (a[11:8] == 4'h2) return "R4";
        if (a[11:8] == 4'h3) return "R5";
        if (a[11:8] == 4'h4) return "R6";
        if (a == 12'hF00)    return "R7";
        return "R11";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with an optional write; model advanced from the requirements
    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                        input logic [NS-1:0] req, input logic [NS-1:0] act);
        logic [NS-1:0] sws, swc, hws, hwc, en_n, pd_n;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; irq_req = req; core_active = act;
        sws = we ? mask_of(a, 12'h200, d) : '0;
        swc = we ? mask_of(a, 12'h280, d) : '0;
        if (we && a == 12'hF00 && int'(d[8:0]) < NS) sws[d[8:0]] = 1'b1;
        hws = req & ~reqp_m;
        hwc = act & ~actp_m & ~req;
        en_n = we ? ((en_m | mask_of(a, 12'h100, d)) & ~mask_of(a, 12'h180, d)) : en_m;
        pd_n = (pd_m & ~swc & ~hwc) | sws | hws;
        @(posedge clk);
        en_m = en_n; pd_m = pd_n; act_m = act; reqp_m = req; actp_m = act;
        if (we && a >= 12'h400 && a <= 12'h420 && a[1:0] == 2'b00)
            for (int b = 0; b < 4; b++) begin
                int s = int'((a - 12'h400) >> 2) * 4 + b;
                if (s < NS) prio_m[s] = d[8*b+3 +: 5];
            end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, irq_req, core_active);
    endtask

    task automatic rd_chk(input logic [11:0] a, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(tag, {32'h0, bus_rdata}, {32'h0, exp_rd(a)});
        check("R12", {29'h0, irq_out}, {29'h0, en_m & pd_m});
    endtask

    logic [11:0] addr_list [20] = '{12'h100, 12'h104, 12'h180, 12'h184, 12'h200, 12'h204,
        12'h280, 12'h284, 12'h300, 12'h304, 12'h400, 12'h404, 12'h410, 12'h41C, 12'h420,
        12'hF00, 12'h424, 12'h108, 12'h308, 12'h102};

    initial begin
        for (int i = 0; i < NS; i++) prio_m[i] = '0;
        repeat (200_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        // R1 reset state
        for (int k = 0; k < 20; k++) rd_chk(addr_list[k], "R1");
        @(negedge clk) rst_n = 1'b1;

        // R2 / R11 set enables, upper bits dropped
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h104, 32'hFFFF_FFFF);
        @(negedge clk); bus_we = 0; bus_addr = 12'h184; #1;
        check("R11", {32'h0, bus_rdata}, 64'h7);
        rd_chk(12'h180, "R2");
        wr(12'h100, 32'h0);
        rd_chk(12'h100, "R2");
        // R3 clear subset
        wr(12'h180, 32'h0000_00F0);
        @(negedge clk); bus_we = 0; bus_addr = 12'h100; #1;
        check("R3", {32'h0, bus_rdata}, 64'hFFFF_FF0F);
        // R7 trigger in and out of range
        wr(12'hF00, 32'd40);
        rd_chk(12'h204, "R7");
        wr(12'hF00, 32'd34);
        @(negedge clk); bus_we = 0; bus_addr = 12'h284; #1;
        check("R7", {32'h0, bus_rdata}, 64'h4);
        rd_chk(12'hF00, "R7");
        // R6 / R11 last priority word
        wr(12'h420, 32'hFFFF_FFFF);
        @(negedge clk); bus_we = 0; bus_addr = 12'h420; #1;
        check("R6", {32'h0, bus_rdata}, 64'h00F8_F8F8);
        wr(12'h404, 32'h1234_5678);
        @(negedge clk); bus_we = 0; bus_addr = 12'h404; #1;
        check("R6", {32'h0, bus_rdata}, 64'h1030_5078);
        // R5 writes to active ignored
        step(1'b1, 12'h300, 32'hFFFF_FFFF, '0, 35'h1);
        @(negedge clk); bus_we = 0; bus_addr = 12'h300; #1;
        check("R5", {32'h0, bus_rdata}, 64'h1);
        step(1'b0, 12'h0, 32'h0, '0, '0);
        // R8 request edge
        step(1'b0, 12'h0, 32'h0, 35'h20, '0);
        @(negedge clk); bus_we = 0; bus_addr = 12'h200; #1;
        check("R8", {32'h0, bus_rdata & 32'h20}, 64'h20);
        // R9 active edge with request high keeps pending
        step(1'b0, 12'h0, 32'h0, 35'h20, 35'h20);
        rd_chk(12'h200, "R9");
        @(negedge clk); bus_we = 0; bus_addr = 12'h200; #1;
        check("R9", {32'h0, bus_rdata & 32'h20}, 64'h20);
        step(1'b0, 12'h0, 32'h0, '0, '0);
        // R9 active edge with request low clears
        step(1'b0, 12'h0, 32'h0, '0, 35'h20);
        @(negedge clk); bus_we = 0; bus_addr = 12'h280; #1;
        check("R9", {32'h0, bus_rdata & 32'h20}, 64'h0);
        // R10 clear-pending and rising request together
        step(1'b1, 12'h280, 32'h0000_0100, 35'h100, '0);
        @(negedge clk); bus_we = 0; bus_addr = 12'h200; #1;
        check("R10", {32'h0, bus_rdata & 32'h100}, 64'h100);
        // R12 enabled-and-pending output
        wr(12'h100, 32'h0000_0100);
        rd_chk(12'h200, "R12");

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [NS-1:0] rq, ac;
            a  = ($urandom % 8 == 0) ? 12'($urandom) : addr_list[$urandom % 20];
            rq = irq_req ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            ac = core_active ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            step($urandom % 2 == 0, a, $urandom, rq, ac);
            a = addr_list[$urandom % 20];
            rd_chk(a, tag_of(a));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule